// File: doc/BRIEF.md
# DRAM Strobe Timing Controller

This block sequences the row strobe, the two column strobes and the two write strobes of a small asynchronous DRAM port. A single request carries an address, a read/write flag, a width flag (byte or halfword) and two byte-lane enables. The controller presents the address, runs a precharge phase, drops the row strobe, opens one column state with the strobes that the access needs, then releases them and gives a one-cycle completion pulse. All strobes are active low.

A 16-bit control register sets three options. Bit 15 chooses how a halfword splits into bytes: per-byte column strobes with one shared write strobe, or one shared column strobe with per-byte write strobes. Bit 14 keeps the row strobe low between accesses, so that the next request skips the row phase. Bit 13 stretches the precharge from one state to two. Bits 12..8 are stored options with no effect here, and bits 7..0 are reserved. A register write made while an access runs is held back and takes effect once the controller is idle again.

States: `ST_IDLE` (waiting; the row strobe is high, or low if held), `ST_PRE` (precharge, row strobe high, 1 or 2 cycles), `ST_ROW` (row strobe low), `ST_COL` (column and write strobes low) and `ST_END` (strobes released, done high). Transitions: IDLE to PRE on a request with the row strobe released; IDLE to COL on a request with the row strobe held; PRE to ROW when the precharge count completes; ROW to COL; COL to END; END to IDLE.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, `ras_n`, `cash_n`, `casl_n`, `wrh_n` and `wrl_n` are high, and `busy` and `done` are low.
- R2: Register bits 15..8 read back the value written; bits 7..0 always read zero.
- R3: For a byte access (`req_wide`=0), only `casl_n` and, on writes, `wrl_n` go low in the column state; `cash_n` and `wrh_n` stay high whatever bit 15 and `req_lanes` hold.
- R4: For a halfword access with bit 15 = 0, `casl_n` goes low if `req_lanes[0]` is set and `cash_n` goes low if `req_lanes[1]` is set; a write drives `wrl_n` low; `wrh_n` stays high.
- R5: For a halfword access with bit 15 = 1, `casl_n` goes low and `cash_n` stays high; a write drives `wrl_n` low if `req_lanes[0]` is set and `wrh_n` low if `req_lanes[1]` is set.
- R6: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. With the row strobe released, `done` is high in the 4th cycle after the accepting edge when bit 13 = 0 (1-cycle precharge) and in the 5th when bit 13 = 1 (2-cycle precharge).
- R7: The column and write strobes are low for exactly one cycle per access, all four are high in the `done` cycle, and `done` lasts one cycle.
- R8: With bit 14 = 0, `ras_n` is high in the `done` cycle and stays high while idle.
- R9: With bit 14 = 1, `ras_n` stays low in the `done` cycle and while idle, and the next request goes straight to the column state, with `done` in the 2nd cycle after the accepting edge.
- R10: `ras_n` falls only after a precharge state. Clearing bit 14 while the row strobe is held raises `ras_n` two cycles after the write cycle, and the next access takes the precharge path.
- R11: A register write made while `busy` is high changes neither the readback nor the running access; it takes effect in the first idle cycle after the access.
- R12: `req_valid` is ignored while `busy` is high: no extra access and no change to `mem_addr`.
- R13: `mem_addr` shows the accepted request address from the accepting edge until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register readback (active value) |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = halfword, 0 = byte |
| req_lanes | input | 2 | Byte lanes of a halfword access (bit 0 low byte) |
| req_addr | input | ADDR_W | Access address |
| busy | output | 1 | Access in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Address of the accepted access |
| ras_n | output | 1 | Row strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| casl_n | output | 1 | Lower (or shared) column strobe, active low |
| wrh_n | output | 1 | Upper-byte write strobe, active low |
| wrl_n | output | 1 | Lower (or shared) write strobe, active low |

## Verification
The assertions assume that a halfword request has at least one lane bit set. Without one, no column strobe would go low, and the checks that pair a column strobe with a held row strobe would see nothing. They also assume that reset is held low from time zero until the first clock edges have passed. The stimulus only issues halfword requests with a nonzero lane mask, and it toggles lanes on byte accesses only to show that they are ignored. Reset is released at a falling edge after several cycles.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int CFG_W     = 16;
    localparam int POS_DWE   = 15;
    localparam int POS_HOLD  = 14;
    localparam int POS_LONG  = 13;
    localparam int OPT_HI    = 12;
    localparam int OPT_LO    = 8;
    localparam int OPT_W     = OPT_HI - OPT_LO + 1;
    localparam int RSV_W     = OPT_LO;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_END
    } dsc_state_e;

    typedef struct packed {
        logic dual_we;
        logic ras_hold;
        logic long_pre;
    } dsc_mode_t;

    typedef struct packed {
        logic       write;
        logic       wide;
        logic [1:0] lanes;
    } dsc_acc_t;

    typedef struct packed {
        logic cash_n;
        logic casl_n;
        logic wrh_n;
        logic wrl_n;
    } dsc_strobe_t;

    localparam dsc_strobe_t STROBE_IDLE = '{cash_n: 1'b1, casl_n: 1'b1, wrh_n: 1'b1, wrl_n: 1'b1};

endpackage

// File: rtl/dsc_cfg_reg.sv
module dsc_cfg_reg
    import dsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             idle_i,
    output dsc_mode_t        mode_o,
    output logic [CFG_W-1:0] rdata_o
);

    dsc_mode_t        mode_q;
    logic [OPT_W-1:0] opt_q;
    logic             pend_q;
    dsc_mode_t        pend_mode_q;
    logic [OPT_W-1:0] pend_opt_q;
    dsc_mode_t        wr_mode;

    always_comb begin
        wr_mode.dual_we  = wdata_i[POS_DWE];
        wr_mode.ras_hold = wdata_i[POS_HOLD];
        wr_mode.long_pre = wdata_i[POS_LONG];
    end

    // Active value changes only at an edge where the sequencer is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            opt_q       <= '0;
            pend_q      <= 1'b0;
            pend_mode_q <= '0;
            pend_opt_q  <= '0;
        end else if (idle_i) begin
            pend_q <= 1'b0;
            if (wr_i) begin
                mode_q <= wr_mode;
                opt_q  <= wdata_i[OPT_HI:OPT_LO];
            end else if (pend_q) begin
                mode_q <= pend_mode_q;
                opt_q  <= pend_opt_q;
            end
        end else if (wr_i) begin
            pend_q      <= 1'b1;
            pend_mode_q <= wr_mode;
            pend_opt_q  <= wdata_i[OPT_HI:OPT_LO];
        end
    end

    assign mode_o  = mode_q;
    assign rdata_o = {mode_q.dual_we, mode_q.ras_hold, mode_q.long_pre, opt_q, {RSV_W{1'b0}}};

    // R11: the active value is frozen while an access runs
    a_r11_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(rdata_o));

    // R11: a deferred write never survives an idle edge
    a_r11_pending_drained: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> !pend_q);

endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
    import dsc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PRE_SHORT = 1,
    parameter int PRE_LONG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  dsc_acc_t          req_acc_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  dsc_mode_t         mode_i,
    output dsc_acc_t          acc_o,
    output logic              dual_we_o,
    output logic              col_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ras_n_o,
    output logic              done_o,
    output logic              busy_o
);

    localparam int CNT_W = (PRE_LONG > 1) ? $clog2(PRE_LONG) : 1;
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(PRE_SHORT - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(PRE_LONG - 1);

    dsc_state_e        state_q, state_d;
    dsc_acc_t          acc_q;
    logic [ADDR_W-1:0] addr_q;
    logic              dwe_q, hold_q, long_q, held_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              accept, pre_last;

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign pre_last = (cnt_q == (long_q ? LAST_LONG : LAST_SHORT));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid_i) state_d = held_q ? ST_COL : ST_PRE;
            ST_PRE:  if (pre_last)    state_d = ST_ROW;
            ST_ROW:  state_d = ST_COL;
            ST_COL:  state_d = ST_END;
            ST_END:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            addr_q  <= '0;
            dwe_q   <= 1'b0;
            hold_q  <= 1'b0;
            long_q  <= 1'b0;
            held_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                acc_q  <= req_acc_i;
                addr_q <= req_addr_i;
                dwe_q  <= mode_i.dual_we;
                hold_q <= mode_i.ras_hold;
                long_q <= mode_i.long_pre;
            end
            if (state_q == ST_PRE) cnt_q <= cnt_q + 1'b1;
            else                   cnt_q <= '0;
            if (state_q == ST_COL)
                held_q <= hold_q;
            else if (state_q == ST_IDLE && !mode_i.ras_hold)
                held_q <= 1'b0;
        end
    end

    always_comb begin
        ras_n_o = 1'b1;
        col_o   = 1'b0;
        done_o  = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin busy_o = 1'b0; ras_n_o = !held_q; end
            ST_PRE:  ras_n_o = 1'b1;
            ST_ROW:  ras_n_o = 1'b0;
            ST_COL:  begin ras_n_o = 1'b0; col_o = 1'b1; end
            ST_END:  begin ras_n_o = !held_q; done_o = 1'b1; end
            default: ras_n_o = 1'b1;
        endcase
    end

    assign acc_o     = acc_q;
    assign dual_we_o = dwe_q;
    assign addr_o    = addr_q;

    // R10: the row strobe falls only when leaving a precharge state
    a_r10_pre_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(state_q) == ST_PRE);

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a held row strobe stays low into idle
    a_r9_held_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ras_n_o) |=> !ras_n_o);

    // R8: a released row strobe stays high into idle
    a_r8_released_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ras_n_o) |=> ras_n_o);

    // R12: no new address is taken while busy
    a_r12_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(addr_o));

endmodule

// File: rtl/dsc_strobe_dec.sv
module dsc_strobe_dec
    import dsc_pkg::*;
(
    input  logic        col_i,
    input  dsc_acc_t    acc_i,
    input  logic        dual_we_i,
    output dsc_strobe_t stb_o
);

    always_comb begin
        stb_o = STROBE_IDLE;
        if (col_i) begin
            unique case ({acc_i.wide, dual_we_i})
                2'b00, 2'b01: begin
                    stb_o.casl_n = 1'b0;
                    stb_o.wrl_n  = !acc_i.write;
                end
                2'b10: begin
                    stb_o.casl_n = !acc_i.lanes[0];
                    stb_o.cash_n = !acc_i.lanes[1];
                    stb_o.wrl_n  = !acc_i.write;
                end
                2'b11: begin
                    stb_o.casl_n = 1'b0;
                    stb_o.wrl_n  = !(acc_i.write && acc_i.lanes[0]);
                    stb_o.wrh_n  = !(acc_i.write && acc_i.lanes[1]);
                end
                default: stb_o = STROBE_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dsc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PRE_SHORT = 1,
    parameter int PRE_LONG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [1:0]        req_lanes,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ras_n,
    output logic              cash_n,
    output logic              casl_n,
    output logic              wrh_n,
    output logic              wrl_n
);

    dsc_mode_t   mode;
    dsc_acc_t    req_acc, acc;
    dsc_strobe_t stb;
    logic        dual_we, col;

    always_comb begin
        req_acc.write = req_write;
        req_acc.wide  = req_wide;
        req_acc.lanes = req_lanes;
    end

    dsc_cfg_reg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (cfg_wdata),
        .idle_i  (!busy),
        .mode_o  (mode),
        .rdata_o (cfg_rdata)
    );

    dsc_seq #(
        .ADDR_W    (ADDR_W),
        .PRE_SHORT (PRE_SHORT),
        .PRE_LONG  (PRE_LONG)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_acc_i   (req_acc),
        .req_addr_i  (req_addr),
        .mode_i      (mode),
        .acc_o       (acc),
        .dual_we_o   (dual_we),
        .col_o       (col),
        .addr_o      (mem_addr),
        .ras_n_o     (ras_n),
        .done_o      (done),
        .busy_o      (busy)
    );

    dsc_strobe_dec i_dec (
        .col_i     (col),
        .acc_i     (acc),
        .dual_we_i (dual_we),
        .stb_o     (stb)
    );

    assign cash_n = stb.cash_n;
    assign casl_n = stb.casl_n;
    assign wrh_n  = stb.wrh_n;
    assign wrl_n  = stb.wrl_n;

    // R7: every column and write strobe is released in the done cycle
    a_r7_release_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cash_n && casl_n && wrh_n && wrl_n));

    // R10: a column strobe is only ever low under a low row strobe
    a_r10_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!cash_n || !casl_n) |-> !ras_n);

    // R3: byte accesses leave the upper-byte strobes quiet
    a_r3_byte_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!casl_n && !acc.wide) |-> (cash_n && wrh_n));

    // R7: a column state lasts exactly one cycle
    a_r7_single_col: assert property (@(posedge clk) disable iff (!rst_n)
        (!cash_n || !casl_n) |=> (cash_n && casl_n));

endmodule

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0]  req_lanes = '0;
    logic [11:0] req_addr = '0;
    logic        busy, done, ras_n, cash_n, casl_n, wrh_n, wrl_n;
    logic [11:0] mem_addr;

    always #5 clk = !clk;

    dram_strobe_ctrl #(.ADDR_W(12)) i_dram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_lanes(req_lanes), .req_addr(req_addr),
        .busy(busy), .done(done), .mem_addr(mem_addr), .ras_n(ras_n),
        .cash_n(cash_n), .casl_n(casl_n), .wrh_n(wrh_n), .wrl_n(wrl_n)
    );

    typedef struct {
        int          start;
        int          lat;
        logic [3:0]  stb;
        logic        ras_after;
        logic [11:0] addr;
        int          mode;
    } exp_t;

    exp_t q_exp[$];
    int   n_chk = 0, n_fail = 0, cyc = 0, n_done = 0, n_push = 0;
    int   col_cnt = 0;
    logic [3:0] col_stb = 4'hF;
    logic m_dwe = 0, m_hold = 0, m_long = 0, m_held = 0, last_hold = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_stb(input logic w, input logic wide,
                                           input logic [1:0] ln, input logic dwe);
        if (!wide)     return {1'b1, 1'b0, 1'b1, !w};
        else if (!dwe) return {!ln[1], !ln[0], 1'b1, !w};
        else           return {1'b1, 1'b0, !(w && ln[1]), !(w && ln[0])};
    endfunction

    function automatic string mode_tag(input int m);
        if (m == 0) return "R3";
        else if (m == 1) return "R4";
        else return "R5";
    endfunction

    // Monitor: pops one expectation per completion pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cash_n || !casl_n) begin
                col_cnt++;
                col_stb = {cash_n, casl_n, wrh_n, wrl_n};
            end
            if (done) begin
                n_done++;
                if (q_exp.size() == 0) begin
                    chk(0, "R12", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    chk(cyc - e.start == e.lat, (e.lat == 2) ? "R9" : "R6",
                        "done latency", cyc - e.start, e.lat);
                    chk(col_stb == e.stb, mode_tag(e.mode), "column strobes {cash,casl,wrh,wrl}",
                        col_stb, e.stb);
                    chk(col_cnt == 1, "R7", "column cycles", col_cnt, 1);
                    chk({cash_n, casl_n, wrh_n, wrl_n} == 4'hF, "R7", "strobes at done",
                        {cash_n, casl_n, wrh_n, wrl_n}, 4'hF);
                    chk(ras_n == e.ras_after, e.ras_after ? "R8" : "R9", "ras_n at done",
                        ras_n, e.ras_after);
                    chk(mem_addr == e.addr, "R13", "mem_addr", mem_addr, e.addr);
                end
                col_cnt = 0;
                col_stb = 4'hF;
            end
        end
    end

    task automatic wr_cfg(input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_dwe = d[15]; m_hold = d[14]; m_long = d[13];
        chk(cfg_rdata == {d[15:8], 8'h00}, "R2", "register readback", cfg_rdata, {d[15:8], 8'h00});
    endtask

    task automatic start_access(input logic w, input logic wide,
                                input logic [1:0] ln, input logic [11:0] a);
        exp_t e;
        @(negedge clk);
        e.start     = cyc;
        e.lat       = m_held ? 2 : (m_long ? 5 : 4);
        e.stb       = exp_stb(w, wide, ln, m_dwe);
        e.ras_after = !m_hold;
        e.addr      = a;
        e.mode      = !wide ? 0 : (m_dwe ? 2 : 1);
        last_hold   = m_hold;
        q_exp.push_back(e);
        n_push++;
        req_valid = 1'b1; req_write = w; req_wide = wide; req_lanes = ln; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        m_held = last_hold;
    endtask

    task automatic access(input logic w, input logic wide,
                          input logic [1:0] ln, input logic [11:0] a);
        start_access(w, wide, ln, a);
        wait_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cfg_rdata == 16'h0000, "R1", "register after reset", cfg_rdata, 0);
        chk({ras_n, cash_n, casl_n, wrh_n, wrl_n} == 5'h1F, "R1", "strobes after reset",
            {ras_n, cash_n, casl_n, wrh_n, wrl_n}, 5'h1F);
        chk({busy, done} == 2'b00, "R1", "busy/done after reset", {busy, done}, 0);

        // R2: reserved low byte
        wr_cfg(16'hFFFF);
        wr_cfg(16'h1F5A);
        wr_cfg(16'h0000);

        // R3 / R4: dual-CAS mode
        access(1, 0, 2'b10, 12'h101);
        access(0, 0, 2'b00, 12'h102);
        access(1, 1, 2'b11, 12'h103);
        access(0, 1, 2'b01, 12'h104);
        access(1, 1, 2'b10, 12'h105);

        // R5 / R3: dual-WE mode
        wr_cfg(16'h8000);
        access(1, 1, 2'b11, 12'h201);
        access(1, 1, 2'b01, 12'h202);
        access(1, 1, 2'b10, 12'h203);
        access(0, 1, 2'b11, 12'h204);
        access(1, 0, 2'b11, 12'h205);

        // R6: long precharge
        wr_cfg(16'h2000);
        access(1, 1, 2'b11, 12'h301);

        // R9: hold mode
        wr_cfg(16'h4000);
        access(1, 1, 2'b11, 12'h401);
        repeat (3) @(negedge clk);
        chk(ras_n == 1'b0, "R9", "ras_n while idle held", ras_n, 0);
        access(0, 1, 2'b01, 12'h402);
        access(1, 0, 2'b00, 12'h403);

        // R10: release of held row strobe
        wr_cfg(16'h0000);
        m_held = 0;
        @(negedge clk);
        chk(ras_n == 1'b1, "R10", "ras_n after hold cleared", ras_n, 1);
        access(1, 1, 2'b11, 12'h501);

        // R11: write during an access is deferred
        start_access(1, 1, 2'b11, 12'h601);
        cfg_wr = 1'b1; cfg_wdata = 16'h2000;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(cfg_rdata == 16'h0000, "R11", "readback during access", cfg_rdata, 0);
        wait_idle();
        @(negedge clk);
        chk(cfg_rdata == 16'h2000, "R11", "readback after access", cfg_rdata, 16'h2000);
        m_long = 1;
        access(0, 1, 2'b10, 12'h602);

        // R12: requests while busy are ignored
        start_access(1, 1, 2'b11, 12'h701);
        req_valid = 1'b1; req_addr = 12'hAAA; req_wide = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (6) @(negedge clk);
        chk(n_done == n_push, "R12", "completion count", n_done, n_push);
        chk(q_exp.size() == 0, "R12", "pending expectations", q_exp.size(), 0);

        summary();
    end

endmodule